// File: doc/BRIEF.md
# SMBus Host Command Sequencer

This block is a bus master for the two-wire SMBus. Software programs it through a small byte-wide register file. It loads the slave address with its direction bit, a command code and up to two data bytes. It then writes a protocol code together with a start bit into the control register. From there the block generates every clock and data edge of the chosen protocol by itself: start, repeated start, address, command, data, acknowledge and stop. When the transaction is over, the result appears as sticky flags in the status register. There is no handshake with software per byte.

Four protocols are supported, in both directions where this applies:
- **Quick**: address and direction only.
- **Send/Receive Byte**: one byte, where a send carries the command register as its data.
- **Read/Write Byte Data**: command code plus one data byte.
- **Read/Write Word Data**: command code plus two data bytes, low byte first.

Both bus lines are open-drain. The block drives a line low by raising its enable output, and reads the resolved level back. One bit time lasts four quarter phases of `QDIV` clock cycles each. A slave may stretch the clock while the block has released SCL.

Top module: `smbus_host_seq`

## Requirements
- R1: After reset the status and control registers read 0x00, and both bus lines are released. While the block is not busy, it never drives SCL or SDA.
- R2: Register offsets:
  - 0: status
  - 2: control
  - 3: command
  - 4: address (slave address in bits 7:1, bit 0 set for a read)
  - 5: data low
  - 6: data high

  Software writes to the command, address and data registers read back unchanged.
- R3: A control write with bit 6 set and a protocol code in bits 5:2 starts a transaction. The protocol codes are 0x00 Quick, 0x04 Byte, 0x08 Byte Data and 0x0C Word Data. Status bit 0 (busy) reads 1 until the transaction ends. Control reads back the code bits, with bit 6 reading 0.
- R4: Quick sends START, the address register byte and STOP.
- R5: A Byte write sends START, the address, the command register byte and STOP. A Byte read sends START and the address with bit 0 set. It then receives one byte into data low, answers it with NACK, and sends STOP.
- R6: A Byte Data write sends START, the address, the command and data low, then STOP. A Byte Data read sends START and the address with bit 0 cleared, then the command. It follows with a repeated START and the address with bit 0 set, receives one byte into data low with NACK, and sends STOP.
- R7: A Word Data write sends data low and then data high after the command. A Word Data read receives two bytes after the repeated START. It stores them in data low then data high, ACKs the first and NACKs the second.
- R8: If any byte the block sends is not acknowledged, the block sends STOP and ends the transaction. It sets status bit 2 (device error) and bit 1 (done), and clears busy.
- R9: If SDA reads low while the block releases it during a transmitted data or address bit, the block releases both lines and ends at once. It sets status bit 3 (collision) and bit 1.
- R10: Status bits 4:1 clear when software writes 1 to them. Writing 0 leaves them unchanged. Every transaction end sets bit 1.
- R11: A control write while busy has no effect: the code stays and the running transaction completes unchanged.
- R12: A start with bits 5:4 of the code not zero makes no bus activity. It sets status bit 4 (failed) and bit 1 at once, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RAW | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| scl_oe | output | 1 | Pull SCL low when 1 |
| scl_in | input | 1 | Resolved SCL level |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Resolved SDA level |

## Verification
The properties assume that software issues at most one register write per cycle. They also assume that the wired-AND bus feeds the resolved levels back to `scl_in` and `sda_in`, so a released line reads high unless something else pulls it.

The bench meets this with one write task and a bus model that combines the block, a slave and an injector. It keeps the address and data registers untouched while a transaction runs, except for control in the ignored-start case. It injects a low SDA level only after the start condition and while SCL is low.

// File: rtl/smbus_host_seq.sv
module smbus_host_seq #(
  parameter int QDIV = 4,
  parameter int RAW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  output logic           scl_oe,
  input  logic           scl_in,
  output logic           sda_oe,
  input  logic           sda_in
);
  localparam int CW = (QDIV > 1) ? $clog2(QDIV) : 1;
  localparam logic [RAW-1:0] A_STS = RAW'(0);
  localparam logic [RAW-1:0] A_CTL = RAW'(2);
  localparam logic [RAW-1:0] A_CMD = RAW'(3);
  localparam logic [RAW-1:0] A_ADR = RAW'(4);
  localparam logic [RAW-1:0] A_DLO = RAW'(5);
  localparam logic [RAW-1:0] A_DHI = RAW'(6);

  localparam logic [3:0] O_START = 4'd0;
  localparam logic [3:0] O_ADRW  = 4'd1;
  localparam logic [3:0] O_ADR   = 4'd2;
  localparam logic [3:0] O_CMD   = 4'd3;
  localparam logic [3:0] O_DLO   = 4'd4;
  localparam logic [3:0] O_DHI   = 4'd5;
  localparam logic [3:0] O_RXLA  = 4'd6;
  localparam logic [3:0] O_RXLN  = 4'd7;
  localparam logic [3:0] O_RXHN  = 4'd8;
  localparam logic [3:0] O_STOP  = 4'd9;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BYTE, S_STOP} st_t;

  function automatic logic [3:0] op_at(input logic [1:0] pr, input logic rdn, input logic [3:0] kk);
    logic [3:0] r;
    r = O_STOP;
    if (kk == 4'd0) r = O_START;
    else case (pr)
      2'd0: if (kk == 4'd1) r = O_ADR;
      2'd1: case (kk)
              4'd1: r = O_ADR;
              4'd2: r = rdn ? O_RXLN : O_CMD;
              default: ;
            endcase
      2'd2: if (!rdn) case (kk)
              4'd1: r = O_ADR;
              4'd2: r = O_CMD;
              4'd3: r = O_DLO;
              default: ;
            endcase
            else case (kk)
              4'd1: r = O_ADRW;
              4'd2: r = O_CMD;
              4'd3: r = O_START;
              4'd4: r = O_ADR;
              4'd5: r = O_RXLN;
              default: ;
            endcase
      default: if (!rdn) case (kk)
              4'd1: r = O_ADR;
              4'd2: r = O_CMD;
              4'd3: r = O_DLO;
              4'd4: r = O_DHI;
              default: ;
            endcase
            else case (kk)
              4'd1: r = O_ADRW;
              4'd2: r = O_CMD;
              4'd3: r = O_START;
              4'd4: r = O_ADR;
              4'd5: r = O_RXLA;
              4'd6: r = O_RXHN;
              default: ;
            endcase
    endcase
    return r;
  endfunction

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    ph;
  logic [3:0]    k, bitn, ctl_q;
  logic [7:0]    sh, cmd_q, adr_q, dlo_q, dhi_q, tx_nxt;
  logic [4:1]    flg;
  logic          nack_q, scl_lo, sda_lo;

  logic       busy, stretch, tick, ctl_wr, go, cur_rx;
  logic [3:0] cur_op, nxt_op;

  assign busy    = st != S_IDLE;
  assign stretch = (ph == 2'd2) && !scl_in;
  assign tick    = busy && !stretch && (cnt == CW'(QDIV - 1));
  assign ctl_wr  = reg_wr && (reg_addr == A_CTL);
  assign go      = ctl_wr && !busy && reg_wdata[6];
  assign cur_op  = op_at(ctl_q[1:0], adr_q[0], k);
  assign nxt_op  = op_at(ctl_q[1:0], adr_q[0], k + 4'd1);
  assign cur_rx  = (cur_op == O_RXLA) || (cur_op == O_RXLN) || (cur_op == O_RXHN);
  assign scl_oe  = scl_lo;
  assign sda_oe  = sda_lo;

  always_comb begin
    case (nxt_op)
      O_ADRW:  tx_nxt = {adr_q[7:1], 1'b0};
      O_ADR:   tx_nxt = adr_q;
      O_CMD:   tx_nxt = cmd_q;
      O_DLO:   tx_nxt = dlo_q;
      O_DHI:   tx_nxt = dhi_q;
      default: tx_nxt = 8'hFF;
    endcase
  end

  always_comb begin
    case (reg_addr)
      A_STS:   reg_rdata = {3'b000, flg, busy};
      A_CTL:   reg_rdata = {2'b00, ctl_q, 2'b00};
      A_CMD:   reg_rdata = cmd_q;
      A_ADR:   reg_rdata = adr_q;
      A_DLO:   reg_rdata = dlo_q;
      A_DHI:   reg_rdata = dhi_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ph <= 2'd0; k <= 4'd0; bitn <= 4'd0; ctl_q <= 4'd0;
      sh <= 8'h00; cmd_q <= 8'h00; adr_q <= 8'h00; dlo_q <= 8'h00; dhi_q <= 8'h00;
      flg <= 4'b0000; nack_q <= 1'b0; scl_lo <= 1'b0; sda_lo <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          A_STS: flg <= flg & ~reg_wdata[4:1];
          A_CMD: cmd_q <= reg_wdata;
          A_ADR: adr_q <= reg_wdata;
          A_DLO: dlo_q <= reg_wdata;
          A_DHI: dhi_q <= reg_wdata;
          default: ;
        endcase
      end
      if (ctl_wr && !busy) ctl_q <= reg_wdata[5:2];
      if (go) begin
        if (reg_wdata[5:4] == 2'b00) begin
          st <= S_START; k <= 4'd0; ph <= 2'd0; cnt <= '0; nack_q <= 1'b0;
        end else begin
          flg[4] <= 1'b1; flg[1] <= 1'b1;
        end
      end
      if (busy) begin
        cnt <= tick ? '0 : (stretch ? cnt : cnt + CW'(1));
        if (tick) begin
          ph <= ph + 2'd1;
          case (st)
            S_START: case (ph)
              2'd0: sda_lo <= 1'b0;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b1;
              default: begin
                scl_lo <= 1'b1;
                k <= k + 4'd1; bitn <= 4'd0; sh <= tx_nxt;
                st <= (nxt_op == O_START) ? S_START : (nxt_op == O_STOP) ? S_STOP : S_BYTE;
              end
            endcase
            S_BYTE: case (ph)
              2'd0: sda_lo <= (bitn == 4'd8) ? (cur_op == O_RXLA) : (!cur_rx && !sh[7]);
              2'd1: scl_lo <= 1'b0;
              2'd2: begin
                if (bitn != 4'd8) begin
                  sh <= {sh[6:0], sda_in};
                  if (!cur_rx && !sda_lo && !sda_in) begin
                    st <= S_IDLE; scl_lo <= 1'b0; sda_lo <= 1'b0;
                    flg[3] <= 1'b1; flg[1] <= 1'b1;
                  end
                end else if (!cur_rx && sda_in) nack_q <= 1'b1;
              end
              default: begin
                scl_lo <= 1'b1;
                if (bitn == 4'd8) begin
                  if (cur_op == O_RXHN) dhi_q <= sh;
                  else if (cur_rx) dlo_q <= sh;
                  if (nack_q) st <= S_STOP;
                  else begin
                    k <= k + 4'd1; bitn <= 4'd0; sh <= tx_nxt;
                    st <= (nxt_op == O_START) ? S_START : (nxt_op == O_STOP) ? S_STOP : S_BYTE;
                  end
                end else bitn <= bitn + 4'd1;
              end
            endcase
            S_STOP: case (ph)
              2'd0: sda_lo <= 1'b1;
              2'd1: scl_lo <= 1'b0;
              2'd2: sda_lo <= 1'b0;
              default: begin
                st <= S_IDLE; flg[1] <= 1'b1;
                if (nack_q) flg[2] <= 1'b1;
              end
            endcase
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/smbus_host_seq_chk.sv
module smbus_host_seq_chk #(
  parameter int RAW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [RAW-1:0] reg_addr,
  input logic [7:0]     reg_wdata,
  input logic           scl_oe,
  input logic           sda_oe,
  input logic           busy,
  input logic [4:1]     flg,
  input logic [3:0]     ctl
);
  logic start_wr;
  assign start_wr = reg_wr && (reg_addr == RAW'(2)) && reg_wdata[6] && !busy;

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && reg_wdata[5:4] == 2'b00) |=> busy);

  assert_end_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> flg[1]);

  assert_w1c_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_wr && reg_addr == RAW'(0)) |=> ((flg & $past(reg_wdata[4:1])) == 4'b0000));

  assert_ctl_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == RAW'(2)) |=> $stable(ctl));

  assert_bad_code_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_wr && reg_wdata[5:4] != 2'b00) |=> (!busy && flg[4] && flg[1]));
endmodule

bind smbus_host_seq smbus_host_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .busy(busy), .flg(flg), .ctl(ctl_q)
);

// File: tb/smbus_host_seq_bench.sv
module smbus_host_seq_bench;
  localparam int QD = 4;
  localparam logic [6:0] SLV = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  logic scl_oe, sda_oe, scl_bus, sda_bus;
  logic s_drv = 1'b0, inject = 1'b0;

  always #2 clk = ~clk;

  assign scl_bus = ~scl_oe;
  assign sda_bus = ~(sda_oe | s_drv | inject);

  smbus_host_seq #(.QDIV(QD), .RAW(3)) u_smbus_host_seq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl_oe(scl_oe), .scl_in(scl_bus), .sda_oe(sda_oe), .sda_in(sda_bus)
  );

  int checks = 0, errors = 0;
  string cur_req = "R1";
  logic [9:0] expq[$];
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic exp_tok(logic [1:0] kind, logic [7:0] b);
    expq.push_back({kind, b});
  endtask

  task automatic observe(logic [9:0] tok);
    logic [9:0] e;
    if (expq.size() == 0) chk(cur_req, "unexpected bus token", {22'd0, tok}, 32'h3FF);
    else begin
      e = expq.pop_front();
      chk(cur_req, "bus token", {22'd0, tok}, {22'd0, e});
    end
  endtask

  logic p_scl = 1'b1, p_sda = 1'b1, active = 1'b0, first = 1'b0, tx = 1'b0, go_tx = 1'b0, mack = 1'b0;
  logic [1:0] mack_h = 2'b00;
  logic [7:0] shreg = 8'h00, txb = 8'h00;
  int bitcnt = 0, txi = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_scl && scl_bus && p_sda && !sda_bus) begin
        observe({2'd1, 8'h00});
        active = 1; first = 1; bitcnt = 0; tx = 0; go_tx = 0; s_drv = 0;
      end else if (p_scl && scl_bus && !p_sda && sda_bus) begin
        observe({2'd2, 8'h00});
        active = 0; tx = 0; go_tx = 0; s_drv = 0;
      end else if (active && !p_scl && scl_bus) begin
        if (bitcnt < 8) begin
          if (!tx) shreg = {shreg[6:0], sda_bus};
          bitcnt++;
        end else if (bitcnt == 8) begin
          if (tx) begin mack = sda_bus; mack_h = {mack_h[0], sda_bus}; end
          bitcnt = 9;
        end
      end else if (active && p_scl && !scl_bus) begin
        if (bitcnt == 8) begin
          if (tx) begin observe({2'd0, txb}); s_drv = 0; end
          else begin
            observe({2'd0, shreg});
            if (first) begin
              first = 0;
              if (shreg[7:1] == SLV) begin s_drv = 1; go_tx = shreg[0]; end
              else active = 0;
            end else s_drv = 1;
          end
        end else if (bitcnt == 9) begin
          bitcnt = 0; s_drv = 0;
          if (go_tx) begin
            go_tx = 0; tx = 1; txi = 0; txb = 8'hA5; s_drv = !txb[7];
          end else if (tx) begin
            if (mack) tx = 0;
            else begin txi++; txb = (txi == 1) ? 8'h3C : 8'hC3; s_drv = !txb[7]; end
          end
        end else if (tx) s_drv = !txb[7 - bitcnt];
      end
      p_scl = scl_bus; p_sda = sda_bus;
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      rd(3'd0, s);
      if (!s[0]) return;
    end
    chk(cur_req, "busy never cleared", 32'd1, 32'd0);
  endtask

  task automatic run(logic [7:0] c);
    wr(3'd2, c);
    wait_idle();
    repeat (4) @(negedge clk);
    chk(cur_req, "tokens left", expq.size(), 0);
  endtask

  task automatic chk_reg(string req, string what, logic [2:0] a, logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, what, {24'd0, v}, {24'd0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    chk_reg("R1", "status after reset", 3'd0, 8'h00);
    chk_reg("R1", "control after reset", 3'd2, 8'h00);
    chk("R1", "lines released", {30'd0, scl_bus, sda_bus}, 32'd3);

    cur_req = "R2";
    wr(3'd3, 8'h9E); wr(3'd4, 8'h54); wr(3'd5, 8'h11); wr(3'd6, 8'h22);
    chk_reg("R2", "command", 3'd3, 8'h9E);
    chk_reg("R2", "address", 3'd4, 8'h54);
    chk_reg("R2", "data low", 3'd5, 8'h11);
    chk_reg("R2", "data high", 3'd6, 8'h22);

    cur_req = "R4";
    exp_tok(1, 0); exp_tok(0, 8'h54); exp_tok(2, 0);
    run(8'h40);
    chk_reg("R4", "quick status", 3'd0, 8'h02);

    cur_req = "R10";
    wr(3'd0, 8'h00);
    chk_reg("R10", "write zero keeps flags", 3'd0, 8'h02);
    wr(3'd0, 8'h02);
    chk_reg("R10", "write one clears", 3'd0, 8'h00);

    cur_req = "R5";
    exp_tok(1, 0); exp_tok(0, 8'h54); exp_tok(0, 8'h9E); exp_tok(2, 0);
    run(8'h44);
    chk_reg("R5", "send byte status", 3'd0, 8'h02);
    chk_reg("R3", "code kept in control", 3'd2, 8'h04);
    wr(3'd0, 8'h1E);
    wr(3'd4, 8'h55);
    exp_tok(1, 0); exp_tok(0, 8'h55); exp_tok(0, 8'hA5); exp_tok(2, 0);
    run(8'h44);
    chk_reg("R5", "receive byte data", 3'd5, 8'hA5);
    chk("R5", "final byte NACK", {31'd0, mack_h[0]}, 32'd1);
    wr(3'd0, 8'h1E);

    cur_req = "R6";
    wr(3'd4, 8'h54); wr(3'd3, 8'h30); wr(3'd5, 8'h5A);
    exp_tok(1, 0); exp_tok(0, 8'h54); exp_tok(0, 8'h30); exp_tok(0, 8'h5A); exp_tok(2, 0);
    run(8'h48);
    chk_reg("R6", "byte data write status", 3'd0, 8'h02);
    wr(3'd0, 8'h1E);
    wr(3'd4, 8'h55); wr(3'd3, 8'h31); wr(3'd5, 8'h00);
    exp_tok(1, 0); exp_tok(0, 8'h54); exp_tok(0, 8'h31);
    exp_tok(1, 0); exp_tok(0, 8'h55); exp_tok(0, 8'hA5); exp_tok(2, 0);
    run(8'h48);
    chk_reg("R6", "byte data read", 3'd5, 8'hA5);
    wr(3'd0, 8'h1E);

    cur_req = "R7";
    wr(3'd4, 8'h54); wr(3'd3, 8'h32); wr(3'd5, 8'h34); wr(3'd6, 8'h12);
    exp_tok(1, 0); exp_tok(0, 8'h54); exp_tok(0, 8'h32); exp_tok(0, 8'h34); exp_tok(0, 8'h12); exp_tok(2, 0);
    run(8'h4C);
    chk_reg("R7", "word write status", 3'd0, 8'h02);
    wr(3'd0, 8'h1E);
    wr(3'd4, 8'h55); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    exp_tok(1, 0); exp_tok(0, 8'h54); exp_tok(0, 8'h32);
    exp_tok(1, 0); exp_tok(0, 8'h55); exp_tok(0, 8'hA5); exp_tok(0, 8'h3C); exp_tok(2, 0);
    run(8'h4C);
    chk_reg("R7", "word read low", 3'd5, 8'hA5);
    chk_reg("R7", "word read high", 3'd6, 8'h3C);
    chk("R7", "ACK then NACK", {30'd0, mack_h}, 32'd1);
    wr(3'd0, 8'h1E);

    cur_req = "R8";
    wr(3'd4, 8'h22);
    exp_tok(1, 0); exp_tok(0, 8'h22); exp_tok(2, 0);
    run(8'h40);
    chk_reg("R8", "no-ack status", 3'd0, 8'h06);
    wr(3'd0, 8'h1E);

    cur_req = "R11";
    wr(3'd4, 8'h54); wr(3'd3, 8'h40); wr(3'd5, 8'h01); wr(3'd6, 8'h02);
    exp_tok(1, 0); exp_tok(0, 8'h54); exp_tok(0, 8'h40); exp_tok(0, 8'h01); exp_tok(0, 8'h02); exp_tok(2, 0);
    wr(3'd2, 8'h4C);
    repeat (40) @(negedge clk);
    wr(3'd2, 8'h40);
    chk_reg("R11", "control unchanged", 3'd2, 8'h0C);
    chk_reg("R11", "still busy", 3'd0, 8'h01);
    wait_idle();
    repeat (4) @(negedge clk);
    chk("R11", "tokens left", expq.size(), 0);
    chk_reg("R11", "single completion", 3'd0, 8'h02);
    wr(3'd0, 8'h1E);

    cur_req = "R12";
    wr(3'd2, 8'h50);
    chk_reg("R12", "failed status", 3'd0, 8'h12);
    repeat (200) @(negedge clk);
    chk("R12", "no bus activity", {30'd0, scl_bus, sda_bus}, 32'd3);
    wr(3'd0, 8'h1E);

    cur_req = "R9";
    wr(3'd4, 8'h54);
    exp_tok(1, 0); exp_tok(2, 0);
    wr(3'd2, 8'h40);
    repeat (5 * QD + 2) @(negedge clk);
    inject = 1'b1;
    wait_idle();
    chk_reg("R9", "collision status", 3'd0, 8'h0A);
    chk("R9", "SCL released", {31'd0, scl_bus}, 32'd1);
    inject = 1'b0;
    repeat (10) @(negedge clk);
    chk("R9", "tokens left", expq.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule